// File: doc/BRIEF.md
# SDRAM Command Bus Monitor with Bank State Tracking

This block sits beside a single-data-rate SDRAM command bus and samples chip select, the three strobe lines, clock enable, the address and bank inputs and the byte masks on every rising clock edge. Each sampled pattern is decoded into a command code. A small state machine per bank follows row activation, explicit and automatic closing, and the minimum clock gaps between commands. Any ordering or spacing error raises a sticky flag.

The decoded command, the column, the auto-close request and the write mask are registered, so they appear one edge after the command is sampled. The read output-disable follows the mask two clocks after that. The block can run as a passive protocol checker in a verification or debug fabric. It can also act as the command front end of a behavioural memory, which then only has to act on the decoded fields and the per-bank rows.

Each bank runs through three named states. IDLE goes to OPEN on an ACTIVE to that bank. OPEN goes to IDLE on a precharge that hits the bank. OPEN goes to CLOSING on a read or write with an auto-close request. CLOSING goes to IDLE when its burst countdown ends, or at once on a precharge. All other commands leave the state as it is.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: With cs_n high the command code on cmd_o is 0 (INHIBIT). With cs_n low, ras_n/cas_n/we_n decode as follows: 111 gives NOP=1, 011 ACTIVE=2, 101 READ=3, 100 WRITE=4, 110 BURST STOP=5, 010 PRECHARGE=6, 000 LOAD MODE=9. cmd_o shows the command sampled at the previous rising edge.
- R2: Pattern 001 with cs_n low decodes to AUTO REFRESH=7 when cke is high and to SELF REFRESH=8 when cke is low.
- R3: ACTIVE to an IDLE bank b (bank index on ba) sets bank_open_o[b] one edge later. It stores addr as that bank's row in bank_row_o[b*ADDR_W +: ADDR_W].
- R4: PRECHARGE with addr[10] low closes only bank ba. With addr[10] high it closes every bank and ba is ignored. bank_open_o reflects this one edge later.
- R5: READ or WRITE to a bank that is not OPEN sets viol_o[0]. ACTIVE to a bank that is not IDLE sets viol_o[1] and leaves its state and row unchanged.
- R6: LOAD MODE while any bank is open sets viol_o[2] and leaves the mode unchanged. A legal LOAD MODE stores addr[2:0] as the burst code (0→1, 1→2, 2→4, 3→8, 7→full page, others→1) and addr[9] as single-location writes.
- R7: READ or WRITE to an OPEN bank fewer than T_RCD edges after its ACTIVE sets viol_o[3].
- R8: ACTIVE to a bank fewer than T_RP edges after that bank closed sets viol_o[4]. The close may come from a precharge or from the end of an auto-close burst.
- R9: ACTIVE to a bank other than the last activated one, fewer than T_RRD edges after the last ACTIVE, sets viol_o[5].
- R10: ACTIVE to a bank fewer than T_RC edges after its last accepted ACTIVE sets viol_o[6].
- R11: READ or WRITE with addr[10] high puts an OPEN bank into CLOSING. The bank becomes IDLE after the burst length in edges. With a full-page burst code the request is ignored and the bank stays OPEN. In single-location write mode a write closes after one edge.
- R12: wr_mask_o shows the dqm sampled with the command on cmd_o. rd_hiz_o shows the dqm sampled two edges before that one.
- R13: viol_o bits stay set until viol_clr is sampled high. A violation detected in the same edge as the clear is still set.
- R14: On READ or WRITE, col_o is {addr[11], addr[9:0]} and autopre_o is addr[10]. On other commands autopre_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge samples |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| cke | input | 1 | Clock enable (refresh qualifier) |
| addr | input | ADDR_W | Row, column, mode code and A10 qualifier |
| ba | input | log2(NUM_BANKS) | Bank select |
| dqm | input | DQM_W | Byte masks |
| viol_clr | input | 1 | Clears sticky violation flags |
| cmd_o | output | 4 | Decoded command code |
| col_o | output | 11 | Decoded column |
| autopre_o | output | 1 | Auto-close request of a read or write |
| wr_mask_o | output | DQM_W | Write byte mask of the current command |
| rd_hiz_o | output | DQM_W | Read output-disable, mask delayed two clocks |
| bank_open_o | output | NUM_BANKS | Bank not IDLE (OPEN or CLOSING) |
| bank_row_o | output | NUM_BANKS*ADDR_W | Stored row per bank |
| viol_o | output | 7 | Sticky violation flags |

## Verification
The bench builds the monitor with four banks, T_RCD=3, T_RP=3, T_RRD=2 and T_RC=6. With T_RRD shorter than T_RCD, two ACTIVEs one edge apart and an early READ each raise their own flag in back-to-back cycles, which shows that the flags accumulate. With T_RC twice T_RP, an ACTIVE can be placed where the row-cycle gap fails while the precharge gap is still met, so the two are seen apart. The short gaps also bring the auto-close countdown of a four-beat burst and the T_RP window that follows it within a few dozen cycles.

// File: rtl/sdr_mon_pkg.sv
package sdr_mon_pkg;

    typedef enum logic [3:0] {
        CMD_INHIBIT   = 4'd0,
        CMD_NOP       = 4'd1,
        CMD_ACTIVE    = 4'd2,
        CMD_READ      = 4'd3,
        CMD_WRITE     = 4'd4,
        CMD_BST       = 4'd5,
        CMD_PRECHARGE = 4'd6,
        CMD_AUTO_REF  = 4'd7,
        CMD_SELF_REF  = 4'd8,
        CMD_LOAD_MODE = 4'd9
    } sdr_cmd_e;

    typedef enum logic [1:0] {
        BANK_IDLE    = 2'd0,
        BANK_OPEN    = 2'd1,
        BANK_CLOSING = 2'd2
    } bank_state_e;

    localparam int VIOL_W        = 7;
    localparam int V_ACC_IDLE    = 0;
    localparam int V_ACT_OPEN    = 1;
    localparam int V_MODE_BUSY   = 2;
    localparam int V_RCD         = 3;
    localparam int V_RP          = 4;
    localparam int V_RRD         = 5;
    localparam int V_RC          = 6;

endpackage

// File: rtl/sdr_cmd_decode.sv
module sdr_cmd_decode
    import sdr_mon_pkg::*;
(
    input  logic     cs_n,
    input  logic     ras_n,
    input  logic     cas_n,
    input  logic     we_n,
    input  logic     cke,
    output sdr_cmd_e cmd
);

    always_comb begin
        cmd = CMD_NOP;
        if (cs_n) begin
            cmd = CMD_INHIBIT;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b111: cmd = CMD_NOP;
                3'b011: cmd = CMD_ACTIVE;
                3'b101: cmd = CMD_READ;
                3'b100: cmd = CMD_WRITE;
                3'b110: cmd = CMD_BST;
                3'b010: cmd = CMD_PRECHARGE;
                3'b001: cmd = cke ? CMD_AUTO_REF : CMD_SELF_REF;
                3'b000: cmd = CMD_LOAD_MODE;
            endcase
        end
    end

endmodule

// File: rtl/sdr_bank_fsm.sv
module sdr_bank_fsm
    import sdr_mon_pkg::*;
#(
    parameter int ROW_W = 13,
    parameter int T_RCD = 3,
    parameter int T_RP  = 3,
    parameter int T_RC  = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  sdr_cmd_e         cmd,
    input  logic             sel,
    input  logic             pre_all,
    input  logic [ROW_W-1:0] row_in,
    input  logic             ap_en,
    input  logic [2:0]       ap_len_m1,
    output logic             is_open,
    output logic [ROW_W-1:0] row_q,
    output logic             v_acc_idle,
    output logic             v_act_open,
    output logic             v_rcd,
    output logic             v_rp,
    output logic             v_rc
);

    localparam int RCD_W = $clog2(T_RCD + 1);
    localparam int RP_W  = $clog2(T_RP + 1);
    localparam int RC_W  = $clog2(T_RC + 1);

    bank_state_e      st_q, st_d;
    logic [2:0]       burst_q;
    logic [RCD_W-1:0] rcd_q;
    logic [RP_W-1:0]  rp_q;
    logic [RC_W-1:0]  rc_q;
    logic             hit_act, hit_acc, hit_pre, take_act;

    assign hit_act  = (cmd == CMD_ACTIVE) && sel;
    assign hit_acc  = ((cmd == CMD_READ) || (cmd == CMD_WRITE)) && sel;
    assign hit_pre  = (cmd == CMD_PRECHARGE) && (sel || pre_all);
    assign take_act = hit_act && (st_q == BANK_IDLE);

    assign v_acc_idle = hit_acc && (st_q != BANK_OPEN);
    assign v_act_open = hit_act && (st_q != BANK_IDLE);
    assign v_rcd      = hit_acc && (st_q == BANK_OPEN) && (rcd_q != '0);
    assign v_rp       = hit_act && (rp_q != '0);
    assign v_rc       = hit_act && (rc_q != '0);
    assign is_open    = (st_q != BANK_IDLE);

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            BANK_IDLE:    if (hit_act) st_d = BANK_OPEN;
            BANK_OPEN:    if (hit_pre) st_d = BANK_IDLE;
                          else if (hit_acc && ap_en) st_d = BANK_CLOSING;
            BANK_CLOSING: if (hit_pre || burst_q == 3'd0) st_d = BANK_IDLE;
            default:      st_d = BANK_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= BANK_IDLE;
        else        st_q <= st_d;
    end

    // row, burst countdown and gap timers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q   <= '0;
            burst_q <= '0;
            rcd_q   <= '0;
            rp_q    <= '0;
            rc_q    <= '0;
        end else begin
            if (take_act) row_q <= row_in;

            if (st_q == BANK_OPEN && st_d == BANK_CLOSING) burst_q <= ap_len_m1;
            else if (st_q == BANK_CLOSING && burst_q != 3'd0) burst_q <= burst_q - 3'd1;

            if (take_act)            rcd_q <= RCD_W'(T_RCD - 1);
            else if (rcd_q != '0)    rcd_q <= rcd_q - 1'b1;

            if (take_act)            rc_q <= RC_W'(T_RC - 1);
            else if (rc_q != '0)     rc_q <= rc_q - 1'b1;

            if (hit_pre || (st_q == BANK_CLOSING && st_d == BANK_IDLE))
                rp_q <= RP_W'(T_RP - 1);
            else if (rp_q != '0)
                rp_q <= rp_q - 1'b1;
        end
    end

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
    import sdr_mon_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 13,
    parameter int DQM_W     = 2,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_RRD     = 3,
    parameter int T_RC      = 9
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cs_n,
    input  logic                        ras_n,
    input  logic                        cas_n,
    input  logic                        we_n,
    input  logic                        cke,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [$clog2(NUM_BANKS)-1:0] ba,
    input  logic [DQM_W-1:0]            dqm,
    input  logic                        viol_clr,
    output logic [3:0]                  cmd_o,
    output logic [10:0]                 col_o,
    output logic                        autopre_o,
    output logic [DQM_W-1:0]            wr_mask_o,
    output logic [DQM_W-1:0]            rd_hiz_o,
    output logic [NUM_BANKS-1:0]        bank_open_o,
    output logic [NUM_BANKS*ADDR_W-1:0] bank_row_o,
    output logic [6:0]                  viol_o
);

    localparam int BA_W  = $clog2(NUM_BANKS);
    localparam int RRD_W = $clog2(T_RRD + 1);

    sdr_cmd_e             cmd;
    logic                 is_rw, wr_one, full_page, ap_en;
    logic [2:0]           bl_code_q, bl_m1, ap_len_m1;
    logic                 wr_single_q;
    logic [RRD_W-1:0]     rrd_q;
    logic [BA_W-1:0]      last_ba_q;
    logic [NUM_BANKS-1:0] open_v, va_idle, va_open, va_rcd, va_rp, va_rc;
    logic [VIOL_W-1:0]    viol_new, viol_q;
    logic [DQM_W-1:0]     dqm_d1, dqm_d2;

    sdr_cmd_decode u_dec (
        .cs_n (cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n (we_n), .cke  (cke),   .cmd  (cmd)
    );

    assign is_rw     = (cmd == CMD_READ) || (cmd == CMD_WRITE);
    assign wr_one    = (cmd == CMD_WRITE) && wr_single_q;
    assign full_page = (bl_code_q == 3'd7);

    always_comb begin
        unique case (bl_code_q)
            3'd1:    bl_m1 = 3'd1;
            3'd2:    bl_m1 = 3'd3;
            3'd3:    bl_m1 = 3'd7;
            default: bl_m1 = 3'd0;
        endcase
    end

    assign ap_len_m1 = wr_one ? 3'd0 : bl_m1;
    assign ap_en     = addr[10] && (wr_one || !full_page);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        sdr_bank_fsm #(
            .ROW_W(ADDR_W), .T_RCD(T_RCD), .T_RP(T_RP), .T_RC(T_RC)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .cmd       (cmd),
            .sel       (ba == BA_W'(b)),
            .pre_all   (addr[10]),
            .row_in    (addr),
            .ap_en     (ap_en),
            .ap_len_m1 (ap_len_m1),
            .is_open   (open_v[b]),
            .row_q     (bank_row_o[b*ADDR_W +: ADDR_W]),
            .v_acc_idle(va_idle[b]),
            .v_act_open(va_open[b]),
            .v_rcd     (va_rcd[b]),
            .v_rp      (va_rp[b]),
            .v_rc      (va_rc[b])
        );
    end

    always_comb begin
        viol_new              = '0;
        viol_new[V_ACC_IDLE]  = |va_idle;
        viol_new[V_ACT_OPEN]  = |va_open;
        viol_new[V_MODE_BUSY] = (cmd == CMD_LOAD_MODE) && (|open_v);
        viol_new[V_RCD]       = |va_rcd;
        viol_new[V_RP]        = |va_rp;
        viol_new[V_RRD]       = (cmd == CMD_ACTIVE) && (rrd_q != '0) && (ba != last_ba_q);
        viol_new[V_RC]        = |va_rc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bl_code_q   <= '0;
            wr_single_q <= 1'b0;
            rrd_q       <= '0;
            last_ba_q   <= '0;
            viol_q      <= '0;
            cmd_o       <= CMD_INHIBIT;
            col_o       <= '0;
            autopre_o   <= 1'b0;
            wr_mask_o   <= '0;
            dqm_d1      <= '0;
            dqm_d2      <= '0;
            rd_hiz_o    <= '0;
        end else begin
            if (cmd == CMD_LOAD_MODE && !(|open_v)) begin
                bl_code_q   <= addr[2:0];
                wr_single_q <= addr[9];
            end
            if (cmd == CMD_ACTIVE) begin
                rrd_q     <= RRD_W'(T_RRD - 1);
                last_ba_q <= ba;
            end else if (rrd_q != '0) begin
                rrd_q <= rrd_q - 1'b1;
            end
            viol_q    <= (viol_clr ? '0 : viol_q) | viol_new;
            cmd_o     <= cmd;
            col_o     <= {addr[11], addr[9:0]};
            autopre_o <= is_rw && addr[10];
            wr_mask_o <= dqm;
            dqm_d1    <= dqm;
            dqm_d2    <= dqm_d1;
            rd_hiz_o  <= dqm_d2;
        end
    end

    assign bank_open_o = open_v;
    assign viol_o      = viol_q;

endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
module sdram_cmd_monitor_chk #(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 13,
    parameter int DQM_W     = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         cs_n,
    input logic                         ras_n,
    input logic                         cas_n,
    input logic                         we_n,
    input logic [ADDR_W-1:0]            addr,
    input logic [$clog2(NUM_BANKS)-1:0] ba,
    input logic [DQM_W-1:0]             dqm,
    input logic                         viol_clr,
    input logic [3:0]                   cmd_o,
    input logic [DQM_W-1:0]             rd_hiz_o,
    input logic [NUM_BANKS-1:0]         bank_open_o,
    input logic [6:0]                   viol_o
);

    logic [1:0] seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             seen_q <= '0;
        else if (seen_q != 2'd3) seen_q <= seen_q + 2'd1;
    end

    assert_inhibit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (cmd_o == 4'd0));

    assert_pre_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !ras_n && cas_n && !we_n && addr[10]) |=> (bank_open_o == '0));

    assert_acc_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && ras_n && !cas_n && !bank_open_o[ba]) |=> viol_o[0]);

    assert_mode_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !ras_n && !cas_n && !we_n && (|bank_open_o)) |=> viol_o[2]);

    assert_read_mask_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q == 2'd3) |-> (rd_hiz_o == $past(dqm, 3)));

    assert_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !viol_clr |=> ((viol_o & $past(viol_o)) == $past(viol_o)));

endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk #(
    .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .DQM_W(DQM_W)
) u_chk (.*);

// File: tb/sdram_cmd_monitor_bench.sv
`timescale 1ns/1ps
module sdram_cmd_monitor_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
    logic [12:0] addr = '0;
    logic [1:0]  ba = '0;
    logic [1:0]  dqm = '0;
    logic        viol_clr = 1'b0;
    logic [3:0]  cmd_o;
    logic [10:0] col_o;
    logic        autopre_o;
    logic [1:0]  wr_mask_o, rd_hiz_o;
    logic [3:0]  bank_open_o;
    logic [51:0] bank_row_o;
    logic [6:0]  viol_o;
    int          errs = 0;
    int          checks = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    sdram_cmd_monitor #(
        .NUM_BANKS(4), .ADDR_W(13), .DQM_W(2),
        .T_RCD(3), .T_RP(3), .T_RRD(2), .T_RC(6)
    ) u_sdram_cmd_monitor (.*);

    // fields: cs ras cas we cke | ba | a10 | expected code
    localparam logic [11:0] VEC [11] = '{
        12'b1_1_1_1_1_00_0_0000,
        12'b0_1_1_1_1_00_0_0001,
        12'b0_0_1_1_1_00_0_0010,
        12'b0_1_0_1_1_00_0_0011,
        12'b0_1_0_0_1_00_0_0100,
        12'b0_1_1_0_1_00_0_0101,
        12'b0_0_1_0_1_00_1_0110,
        12'b0_0_0_1_1_00_0_0111,
        12'b0_0_0_1_0_00_0_1000,
        12'b0_0_0_0_1_00_0_1001,
        12'b1_0_0_0_1_00_0_0000
    };

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic step(input logic c, input logic r, input logic ca, input logic w,
                        input logic k, input logic [1:0] b, input logic [12:0] a,
                        input logic [1:0] m, input logic clr);
        @(negedge clk);
        cs_n = c; ras_n = r; cas_n = ca; we_n = w; cke = k;
        ba = b; addr = a; dqm = m; viol_clr = clr;
        @(posedge clk);
        #1;
    endtask

    task automatic nop(input logic clr, input logic [1:0] m);
        step(0, 1, 1, 1, 1, 2'd0, 13'd0, m, clr);
    endtask
    task automatic act(input logic [1:0] b, input logic [12:0] row);
        step(0, 0, 1, 1, 1, b, row, 2'b00, 0);
    endtask
    task automatic rd(input logic [1:0] b, input logic [12:0] a);
        step(0, 1, 0, 1, 1, b, a, 2'b00, 0);
    endtask
    task automatic wr(input logic [1:0] b, input logic [12:0] a, input logic [1:0] m);
        step(0, 1, 0, 0, 1, b, a, m, 0);
    endtask
    task automatic pre(input logic [1:0] b, input logic all, input logic clr);
        step(0, 0, 1, 0, 1, b, {2'b00, all, 10'd0}, 2'b00, clr);
    endtask
    task automatic lmr(input logic [12:0] a);
        step(0, 0, 0, 0, 1, 2'd0, a, 2'b00, 0);
    endtask

    initial begin
        #400000;
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: got hang expected finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("reset R1 cmd", cmd_o, 0);
        chk("reset R3 open", bank_open_o, 0);
        chk("reset R13 viol", viol_o, 0);
        chk("reset R12 hiz", rd_hiz_o, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // decode table, R1 and R2
        for (int i = 0; i < 11; i++) begin
            step(VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7],
                 VEC[i][6:5], {2'b00, VEC[i][4], 10'd0}, 2'b00, 0);
            chk((i == 7 || i == 8) ? "R2 refresh decode" : "R1 decode", cmd_o, VEC[i][3:0]);
        end

        nop(1, 2'b00);
        chk("R13 clear", viol_o, 0);
        lmr(13'd2);                                  // burst of four
        chk("R6 legal mode", viol_o, 0);

        act(2'd1, 13'h1ABC);                         // E0
        chk("R3 open", bank_open_o, 4'b0010);
        chk("R3 row", bank_row_o[13 +: 13], 13'h1ABC);
        act(2'd2, 13'h0055);                         // E1
        chk("R9 rrd", viol_o, 7'h20);
        rd(2'd1, 13'd5);                             // E2
        chk("R7 rcd sticky R13", viol_o, 7'h28);
        nop(1, 2'b00);                               // E3
        chk("R13 clear", viol_o, 0);
        rd(2'd1, 13'd7);                             // E4
        chk("R7 rcd met", viol_o, 0);
        chk("R14 col", col_o, 11'd7);
        chk("R14 no ap", autopre_o, 0);
        act(2'd1, 13'h0001);                         // E5
        chk("R5 R10 act open rc", viol_o, 7'h42);
        chk("R5 row kept", bank_row_o[13 +: 13], 13'h1ABC);
        nop(1, 2'b00);                               // E6
        pre(2'd1, 0, 0);                             // E7
        chk("R4 single", bank_open_o, 4'b0100);
        act(2'd1, 13'h0002);                         // E8
        chk("R8 rp explicit", viol_o, 7'h10);
        nop(1, 2'b00);                               // E9
        lmr(13'd3);                                  // E10
        chk("R6 mode busy", viol_o, 7'h04);
        pre(2'd3, 1, 1);                             // E11
        chk("R4 all", bank_open_o, 4'b0000);
        chk("R13 clear", viol_o, 0);

        nop(0, 2'b00); nop(0, 2'b00);                // E12, E13
        act(2'd3, 13'h0F0F);                         // E14
        chk("R8 rp met", viol_o, 0);
        nop(0, 2'b00); nop(0, 2'b00);                // E15, E16
        wr(2'd3, 13'h0400, 2'b01);                   // E17
        chk("R1 write", cmd_o, 4);
        chk("R12 wr mask", wr_mask_o, 2'b01);
        chk("R14 ap", autopre_o, 1);
        nop(0, 2'b00); nop(0, 2'b00); nop(0, 2'b00); // E18..E20
        chk("R11 closing", bank_open_o[3], 1);
        nop(0, 2'b00);                               // E21
        chk("R11 closed", bank_open_o[3], 0);
        act(2'd3, 13'h0003);                         // E22
        chk("R8 rp auto", viol_o, 7'h10);
        nop(1, 2'b00);                               // E23
        rd(2'd0, 13'd0);                             // E24
        chk("R5 acc idle", viol_o, 7'h01);
        nop(1, 2'b10);                               // E25
        nop(0, 2'b00);                               // E26
        chk("R12 hiz before", rd_hiz_o, 2'b00);
        nop(0, 2'b00);                               // E27
        chk("R12 hiz", rd_hiz_o, 2'b10);
        nop(0, 2'b00);                               // E28
        chk("R12 hiz after", rd_hiz_o, 2'b00);

        pre(2'd0, 1, 1);                             // E29
        nop(0, 2'b00); nop(0, 2'b00);
        lmr(13'd7);                                  // full page
        chk("R6 full page mode", viol_o, 0);
        nop(0, 2'b00);
        act(2'd0, 13'h0003);
        nop(0, 2'b00); nop(0, 2'b00);
        rd(2'd0, 13'h0C05);
        chk("R14 col a11", col_o, 11'h405);
        for (int i = 0; i < 8; i++) nop(0, 2'b00);
        chk("R11 full page keeps open", bank_open_o[0], 1);
        chk("R11 no viol", viol_o, 0);

        pre(2'd0, 1, 0);
        nop(0, 2'b00); nop(0, 2'b00);
        lmr(13'h0203);                               // burst 8, single writes
        nop(0, 2'b00);
        act(2'd2, 13'h0011);
        nop(0, 2'b00); nop(0, 2'b00);
        wr(2'd2, 13'h0400, 2'b00);
        chk("R11 single write closing", bank_open_o[2], 1);
        nop(0, 2'b00);
        chk("R11 single write closed", bank_open_o[2], 0);
        chk("R11 clean run", viol_o, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule